// File: doc/BRIEF.md
# Serial time distribution receiver

This block sits at the far end of a one-wire time distribution link that runs in the sender's clock domain, one bit per clock. It cuts the bit stream into 17-bit words, each made of a low start bit followed by 16 data bits sent least significant bit first. Fourteen back-to-back words make one message, and a new message begins every 256 clocks.

Every message carries the free-running relative nanosecond count, the fractional nanoseconds, and the integer and fractional parts of the period increment. It also carries one of three rotating payloads: the time-of-day seconds and nanoseconds, the time-of-day offset together with the drift settings, or an alternate offset and seconds pair. The receiver decodes a whole message into wide output fields. A one-cycle valid pulse for the message type marks the update.

Framing is conservative. The receiver starts hunting for a message only after the line has stayed high for at least one full word time. A high level where a start bit belongs aborts the message under way, and a message whose index is not 0, 1 or 2 is dropped whole.

Top module: `tdist_rx`

## Requirements
- R1: A word is a low start bit followed by 16 data bits, least significant bit first. Every decoded field equals the value that the sender packed into the message, so no bit is lost or shifted across the 14 words.
- R2: Word 0 data bits 3:0 hold the message index. Index 0 raises `tod_valid`. It loads `tod_ns` from word 1 (bits 15:0) and word 2 bits 13:0 (bits 29:16), loads `tod_updated` from word 2 bit 15, and loads `tod_sec` from words 3, 4 and 5, lowest part first.
- R3: Index 1 raises `drift_valid`. It loads `offset_ns` from words 1 and 2, low half first, and `drift_num`, `drift_den` and `drift_state` from words 3, 4 and 5.
- R4: Index 2 raises `alt_valid`. It loads `alt_offset_ns` from words 1 and 2 and `alt_sec` from words 3 to 5, each low half first.
- R5: Every accepted message loads the shared fields. `frac_ns` comes from words 6 and 7, `rel_ns` from words 8 to 10, and `period_fns` from words 11 and 12. `period_ns` comes from the low byte of word 13, and the high byte of word 13 is ignored. `rel_updated` comes from word 0 bit 8 and `sec_lsb` from word 0 bit 9.
- R6: A message with an index above 2 produces no valid pulse and leaves every output unchanged.
- R7: A high level at a start-bit position inside a message aborts that message: no valid pulse and no output change.
- R8: A word 0 is accepted only on a falling edge that follows at least 17 consecutive high bits. A message that starts sooner is lost, and the next properly preceded message is received.
- R9: All outputs of a message change together, in the same cycle as its valid pulse. The pulse lasts one cycle, and at most one valid is high at a time.
- R10: A synchronous active-high reset clears all outputs and valids and returns the framer to the hunt state, even in the middle of a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the sender |
| rst | input | 1 | Synchronous reset, active high |
| td_sdi | input | 1 | Serial time distribution line, idles high |
| rel_ns | output | 48 | Relative nanosecond count |
| frac_ns | output | 32 | Fractional nanoseconds |
| period_ns | output | 8 | Integer part of the period increment |
| period_fns | output | 32 | Fractional part of the period increment |
| rel_updated | output | 1 | Relative timestamp was updated at the sender |
| sec_lsb | output | 1 | Least significant bit of time-of-day seconds |
| tod_valid | output | 1 | One-cycle pulse: index 0 message decoded |
| tod_sec | output | 48 | Time-of-day seconds |
| tod_ns | output | 30 | Time-of-day nanoseconds |
| tod_updated | output | 1 | Time-of-day was updated at the sender |
| drift_valid | output | 1 | One-cycle pulse: index 1 message decoded |
| offset_ns | output | 32 | Time-of-day minus relative offset |
| drift_num | output | 16 | Drift numerator |
| drift_den | output | 16 | Drift denominator |
| drift_state | output | 16 | Drift counter state at the sender |
| alt_valid | output | 1 | One-cycle pulse: index 2 message decoded |
| alt_offset_ns | output | 32 | Alternate offset |
| alt_sec | output | 48 | Alternate seconds |

## Verification
The hardest state to reach is a framer that is disarmed while message bits keep arriving. The framer must stay disarmed through the rest of that message, then arm on the inter-message gap. The bench reaches this in two ways. It pulses reset in the middle of word 5 while the driver keeps shifting. It also starts a message only ten high clocks after reset. In both cases a start bit falls every 17 positions, so no run of highs inside a message can re-arm the framer. The next message must still decode correctly. Truncated messages, an out-of-range index and a nonzero reserved byte then check that outputs hold their last values.

// File: rtl/td_rx_pkg.sv
package td_rx_pkg;

    localparam int DATA_W    = 16;
    localparam int WORD_W    = DATA_W + 1;
    localparam int MSG_WORDS = 14;
    localparam int NUM_KINDS = 3;

    typedef enum logic [1:0] {
        FR_HUNT,
        FR_ARMED,
        FR_DATA,
        FR_NEXT
    } fr_state_e;

    typedef struct packed {
        logic [47:0] rel_ns;
        logic [31:0] frac_ns;
        logic [31:0] period_fns;
        logic [7:0]  period_ns;
        logic        rel_updated;
        logic        sec_lsb;
    } td_common_t;

    typedef struct packed {
        logic [47:0] sec;
        logic [29:0] ns;
        logic        updated;
    } td_tod_t;

    typedef struct packed {
        logic [31:0] offset_ns;
        logic [15:0] num;
        logic [15:0] den;
        logic [15:0] state;
    } td_drift_t;

    typedef struct packed {
        logic [31:0] offset_ns;
        logic [47:0] sec;
    } td_alt_t;

    function automatic logic [31:0] join2(input logic [15:0] lo, input logic [15:0] hi);
        return {hi, lo};
    endfunction

    function automatic logic [47:0] join3(input logic [15:0] lo, input logic [15:0] mid,
                                          input logic [15:0] hi);
        return {hi, mid, lo};
    endfunction

endpackage

// File: rtl/td_rx_framer.sv
module td_rx_framer
    import td_rx_pkg::*;
#(
    parameter int DATA_W    = td_rx_pkg::DATA_W,
    parameter int MSG_WORDS = td_rx_pkg::MSG_WORDS,
    localparam int IDX_W    = $clog2(MSG_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sdi,
    output logic              word_stb,
    output logic [DATA_W-1:0] word_data,
    output logic [IDX_W-1:0]  word_idx
);

    localparam int ARM_BITS = DATA_W + 1;
    localparam int RUN_W    = $clog2(ARM_BITS + 1);
    localparam int BIT_W    = $clog2(DATA_W);

    fr_state_e         state;
    logic [RUN_W-1:0]  run_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  cur_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= FR_HUNT;
            run_cnt   <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            cur_idx   <= '0;
            word_stb  <= 1'b0;
            word_data <= '0;
            word_idx  <= '0;
        end else begin
            word_stb <= 1'b0;
            case (state)
                FR_HUNT: begin
                    // count an unbroken run of highs; a full word time arms
                    if (sdi) begin
                        if (run_cnt == RUN_W'(ARM_BITS - 1)) begin
                            state <= FR_ARMED;
                        end else begin
                            run_cnt <= run_cnt + 1'b1;
                        end
                    end else begin
                        run_cnt <= '0;
                    end
                end
                FR_ARMED: begin
                    if (!sdi) begin
                        state   <= FR_DATA;
                        bit_cnt <= '0;
                        cur_idx <= '0;
                    end
                end
                FR_DATA: begin
                    shreg   <= {sdi, shreg[DATA_W-1:1]};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == BIT_W'(DATA_W - 1)) begin
                        word_stb  <= 1'b1;
                        word_data <= {sdi, shreg[DATA_W-1:1]};
                        word_idx  <= cur_idx;
                        if (cur_idx == IDX_W'(MSG_WORDS - 1)) begin
                            state   <= FR_HUNT;
                            run_cnt <= '0;
                        end else begin
                            state <= FR_NEXT;
                        end
                    end
                end
                FR_NEXT: begin
                    if (!sdi) begin
                        state   <= FR_DATA;
                        bit_cnt <= '0;
                        cur_idx <= cur_idx + 1'b1;
                    end else begin
                        // missing start bit: drop the message and rehunt
                        state   <= FR_HUNT;
                        run_cnt <= RUN_W'(1);
                    end
                end
                default: begin
                    state   <= FR_HUNT;
                    run_cnt <= '0;
                end
            endcase
        end
    end

    // R1: consecutive words are a full word time apart
    p_word_gap_r1: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);

    // R7: a high start-bit slot never yields the next word strobe
    p_abort_no_word_r7: assert property (@(posedge clk) disable iff (rst)
        (state == FR_NEXT && sdi) |=> (state == FR_HUNT));

endmodule

// File: rtl/td_rx_decode.sv
module td_rx_decode
    import td_rx_pkg::*;
#(
    parameter int DATA_W    = td_rx_pkg::DATA_W,
    parameter int MSG_WORDS = td_rx_pkg::MSG_WORDS,
    localparam int IDX_W    = $clog2(MSG_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_stb,
    input  logic [DATA_W-1:0] word_data,
    input  logic [IDX_W-1:0]  word_idx,
    output td_common_t        common_q,
    output td_tod_t           tod_q,
    output td_drift_t         drift_q,
    output td_alt_t           alt_q,
    output logic              tod_vld,
    output logic              drift_vld,
    output logic              alt_vld
);

    localparam int LAST = MSG_WORDS - 1;

    logic [MSG_WORDS-1:0][DATA_W-1:0] all_w;

    // hold words 0..LAST-1; the final word is used straight off the framer
    for (genvar g = 0; g < LAST; g++) begin : g_word
        logic [DATA_W-1:0] w_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                w_q <= '0;
            end else if (word_stb && word_idx == IDX_W'(g)) begin
                w_q <= word_data;
            end
        end
        assign all_w[g] = w_q;
    end
    assign all_w[LAST] = word_data;

    logic       fire;
    logic [3:0] msg_idx;
    logic       accept;

    assign fire    = word_stb && (word_idx == IDX_W'(LAST));
    assign msg_idx = all_w[0][3:0];
    assign accept  = fire && (msg_idx < 4'(NUM_KINDS));

    td_common_t nxt_common;
    td_tod_t    nxt_tod;
    td_drift_t  nxt_drift;
    td_alt_t    nxt_alt;

    always_comb begin
        nxt_common.rel_updated = all_w[0][8];
        nxt_common.sec_lsb     = all_w[0][9];
        nxt_common.frac_ns     = join2(all_w[6], all_w[7]);
        nxt_common.rel_ns      = join3(all_w[8], all_w[9], all_w[10]);
        nxt_common.period_fns  = join2(all_w[11], all_w[12]);
        nxt_common.period_ns   = all_w[13][7:0];

        nxt_tod.ns      = {all_w[2][13:0], all_w[1]};
        nxt_tod.updated = all_w[2][15];
        nxt_tod.sec     = join3(all_w[3], all_w[4], all_w[5]);

        nxt_drift.offset_ns = join2(all_w[1], all_w[2]);
        nxt_drift.num       = all_w[3];
        nxt_drift.den       = all_w[4];
        nxt_drift.state     = all_w[5];

        nxt_alt.offset_ns = join2(all_w[1], all_w[2]);
        nxt_alt.sec       = join3(all_w[3], all_w[4], all_w[5]);
    end

    logic unused_bits;
    assign unused_bits = ^{all_w[13][15:8], all_w[0][15:10], all_w[0][7:4], all_w[2][14]};

    always_ff @(posedge clk) begin
        if (rst) begin
            common_q  <= '0;
            tod_q     <= '0;
            drift_q   <= '0;
            alt_q     <= '0;
            tod_vld   <= 1'b0;
            drift_vld <= 1'b0;
            alt_vld   <= 1'b0;
        end else begin
            tod_vld   <= 1'b0;
            drift_vld <= 1'b0;
            alt_vld   <= 1'b0;
            if (accept) begin
                common_q <= nxt_common;
                case (msg_idx)
                    4'd0: begin
                        tod_q   <= nxt_tod;
                        tod_vld <= 1'b1;
                    end
                    4'd1: begin
                        drift_q   <= nxt_drift;
                        drift_vld <= 1'b1;
                    end
                    default: begin
                        alt_q   <= nxt_alt;
                        alt_vld <= 1'b1;
                    end
                endcase
            end
        end
    end

    // R9: only one message type reported at a time
    p_valid_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tod_vld, drift_vld, alt_vld}));

    // R9: a valid lasts a single cycle
    p_valid_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (tod_vld || drift_vld || alt_vld) |=> !(tod_vld || drift_vld || alt_vld));

    // R9: without a completed message every output holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(common_q) && $stable(tod_q) && $stable(drift_q) && $stable(alt_q)));

    // R6: an out-of-range index never raises a valid
    p_bad_index_r6: assert property (@(posedge clk) disable iff (rst)
        (fire && msg_idx >= 4'(NUM_KINDS)) |=> !(tod_vld || drift_vld || alt_vld));

    // R10: reset leaves no valid standing
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !(tod_vld || drift_vld || alt_vld));

endmodule

// File: rtl/tdist_rx.sv
module tdist_rx
    import td_rx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        td_sdi,
    output logic [47:0] rel_ns,
    output logic [31:0] frac_ns,
    output logic [7:0]  period_ns,
    output logic [31:0] period_fns,
    output logic        rel_updated,
    output logic        sec_lsb,
    output logic        tod_valid,
    output logic [47:0] tod_sec,
    output logic [29:0] tod_ns,
    output logic        tod_updated,
    output logic        drift_valid,
    output logic [31:0] offset_ns,
    output logic [15:0] drift_num,
    output logic [15:0] drift_den,
    output logic [15:0] drift_state,
    output logic        alt_valid,
    output logic [31:0] alt_offset_ns,
    output logic [47:0] alt_sec
);

    localparam int IDX_W = $clog2(MSG_WORDS);

    logic              word_stb;
    logic [DATA_W-1:0] word_data;
    logic [IDX_W-1:0]  word_idx;

    td_common_t common_q;
    td_tod_t    tod_q;
    td_drift_t  drift_q;
    td_alt_t    alt_q;

    td_rx_framer #(
        .DATA_W   (DATA_W),
        .MSG_WORDS(MSG_WORDS)
    ) u_framer (
        .clk      (clk),
        .rst      (rst),
        .sdi      (td_sdi),
        .word_stb (word_stb),
        .word_data(word_data),
        .word_idx (word_idx)
    );

    td_rx_decode #(
        .DATA_W   (DATA_W),
        .MSG_WORDS(MSG_WORDS)
    ) u_decode (
        .clk      (clk),
        .rst      (rst),
        .word_stb (word_stb),
        .word_data(word_data),
        .word_idx (word_idx),
        .common_q (common_q),
        .tod_q    (tod_q),
        .drift_q  (drift_q),
        .alt_q    (alt_q),
        .tod_vld  (tod_valid),
        .drift_vld(drift_valid),
        .alt_vld  (alt_valid)
    );

    assign rel_ns        = common_q.rel_ns;
    assign frac_ns       = common_q.frac_ns;
    assign period_ns     = common_q.period_ns;
    assign period_fns    = common_q.period_fns;
    assign rel_updated   = common_q.rel_updated;
    assign sec_lsb       = common_q.sec_lsb;
    assign tod_sec       = tod_q.sec;
    assign tod_ns        = tod_q.ns;
    assign tod_updated   = tod_q.updated;
    assign offset_ns     = drift_q.offset_ns;
    assign drift_num     = drift_q.num;
    assign drift_den     = drift_q.den;
    assign drift_state   = drift_q.state;
    assign alt_offset_ns = alt_q.offset_ns;
    assign alt_sec       = alt_q.sec;

endmodule

// File: tb/test_tdist_rx.sv
`timescale 1ns / 1ps
module test_tdist_rx;

    typedef struct packed {
        logic [1:0]  kind;
        logic [47:0] rel;
        logic [31:0] frac;
        logic [31:0] pfns;
        logic [7:0]  pns;
        logic        rupd;
        logic        slsb;
        logic [47:0] tsec;
        logic [29:0] tns;
        logic        tupd;
        logic [31:0] off;
        logic [15:0] dnum;
        logic [15:0] dden;
        logic [15:0] dst;
        logic [31:0] aoff;
        logic [47:0] asec;
    } fld_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic td_sdi = 1'b1;

    logic [47:0] rel_ns;
    logic [31:0] frac_ns;
    logic [7:0]  period_ns;
    logic [31:0] period_fns;
    logic        rel_updated, sec_lsb;
    logic        tod_valid, drift_valid, alt_valid;
    logic [47:0] tod_sec;
    logic [29:0] tod_ns;
    logic        tod_updated;
    logic [31:0] offset_ns;
    logic [15:0] drift_num, drift_den, drift_state;
    logic [31:0] alt_offset_ns;
    logic [47:0] alt_sec;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    fld_t exp_q[$];
    fld_t last_f = '0;

    always #5 clk = ~clk;

    tdist_rx i_tdist_rx (
        .clk(clk), .rst(rst), .td_sdi(td_sdi),
        .rel_ns(rel_ns), .frac_ns(frac_ns), .period_ns(period_ns),
        .period_fns(period_fns), .rel_updated(rel_updated), .sec_lsb(sec_lsb),
        .tod_valid(tod_valid), .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_updated(tod_updated),
        .drift_valid(drift_valid), .offset_ns(offset_ns), .drift_num(drift_num),
        .drift_den(drift_den), .drift_state(drift_state),
        .alt_valid(alt_valid), .alt_offset_ns(alt_offset_ns), .alt_sec(alt_sec)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic fld_t make_fld(input int s, input logic [1:0] kind);
        fld_t f;
        f.kind = kind;
        f.rel  = 48'h0000_1000_0000 + 48'(s) * 48'h0F0F_1234_5677;
        f.frac = 32'h8000_0001 ^ (32'(s) * 32'h1357_9BDF);
        f.pfns = 32'h3333_3333 + 32'(s) * 32'h0101_0011;
        f.pns  = 8'(6 + s);
        f.rupd = s[0];
        f.slsb = s[1];
        f.tsec = 48'h0000_6512_3400 + 48'(s) * 48'h0001_0203_0405;
        f.tns  = 30'h2AAA_5555 ^ (30'(s) * 30'h0123_4567);
        f.tupd = ~s[0];
        f.off  = 32'hFEDC_BA98 - 32'(s) * 32'h0011_2233;
        f.dnum = 16'h0C0D + 16'(s);
        f.dden = 16'h0005 + 16'(s * 3);
        f.dst  = 16'hA000 | 16'(s);
        f.aoff = 32'h1234_5678 + 32'(s) * 32'h0F00_00F0;
        f.asec = 48'h00FF_0000_FF00 - 48'(s) * 48'h0000_1111_0001;
        return f;
    endfunction

    // field placement per R2..R5; reserved byte of word 13 set nonzero
    function automatic logic [13:0][15:0] pack_msg(input fld_t f, input logic [3:0] idx);
        logic [13:0][15:0] w;
        w = '0;
        w[0] = {6'b0, f.slsb, f.rupd, 4'b0, idx};
        case (idx)
            4'd0: begin
                w[1] = f.tns[15:0];
                w[2] = {f.tupd, 1'b0, f.tns[29:16]};
                w[3] = f.tsec[15:0]; w[4] = f.tsec[31:16]; w[5] = f.tsec[47:32];
            end
            4'd1: begin
                w[1] = f.off[15:0]; w[2] = f.off[31:16];
                w[3] = f.dnum; w[4] = f.dden; w[5] = f.dst;
            end
            default: begin
                w[1] = f.aoff[15:0]; w[2] = f.aoff[31:16];
                w[3] = f.asec[15:0]; w[4] = f.asec[31:16]; w[5] = f.asec[47:32];
            end
        endcase
        w[6]  = f.frac[15:0]; w[7] = f.frac[31:16];
        w[8]  = f.rel[15:0];  w[9] = f.rel[31:16]; w[10] = f.rel[47:32];
        w[11] = f.pfns[15:0]; w[12] = f.pfns[31:16];
        w[13] = {8'hA5, f.pns};
        return w;
    endfunction

    task automatic drive_bit(input logic b);
        @(posedge clk);
        #1 td_sdi = b;
    endtask

    // sends n_words words, then holds the line high for the rest of a 256-clock slot
    task automatic send_frame(input logic [13:0][15:0] w, input int n_words);
        for (int k = 0; k < 14; k++) begin
            for (int b = 0; b < 17; b++) begin
                if (k >= n_words) drive_bit(1'b1);
                else if (b == 0) drive_bit(1'b0);
                else drive_bit(w[k][b-1]);
            end
        end
        for (int i = 0; i < 18; i++) drive_bit(1'b1);
    endtask

    task automatic send_good(input int s, input logic [1:0] kind);
        fld_t f;
        f = make_fld(s, kind);
        exp_q.push_back(f);
        send_frame(pack_msg(f, {2'b00, kind}), 14);
    endtask

    function automatic logic [121:0] act_common();
        return {rel_ns, frac_ns, period_fns, period_ns, rel_updated, sec_lsb};
    endfunction
    function automatic logic [121:0] exp_common(input fld_t f);
        return {f.rel, f.frac, f.pfns, f.pns, f.rupd, f.slsb};
    endfunction
    function automatic logic [238:0] act_spec();
        return {tod_sec, tod_ns, tod_updated, offset_ns, drift_num, drift_den, drift_state,
                alt_offset_ns, alt_sec};
    endfunction
    function automatic logic [238:0] exp_spec(input fld_t f);
        return {f.tsec, f.tns, f.tupd, f.off, f.dnum, f.dden, f.dst, f.aoff, f.asec};
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !done && (tod_valid || drift_valid || alt_valid)) begin
            fld_t e;
            chk($countones({tod_valid, drift_valid, alt_valid}) == 1, "R9", "single valid",
                {tod_valid, drift_valid, alt_valid}, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6/R7/R8", "unexpected valid", {tod_valid, drift_valid, alt_valid}, 0);
            end else begin
                e = exp_q.pop_front();
                case (e.kind)
                    2'd0: begin
                        chk(tod_valid, "R2", "tod_valid", {tod_valid, drift_valid, alt_valid}, 3'b100);
                        chk({tod_sec, tod_ns, tod_updated} == {e.tsec, e.tns, e.tupd}, "R2",
                            "tod fields", {tod_sec, tod_ns, tod_updated}, {e.tsec, e.tns, e.tupd});
                        last_f.tsec = e.tsec; last_f.tns = e.tns; last_f.tupd = e.tupd;
                    end
                    2'd1: begin
                        chk(drift_valid, "R3", "drift_valid", {tod_valid, drift_valid, alt_valid}, 3'b010);
                        chk({offset_ns, drift_num, drift_den, drift_state} == {e.off, e.dnum, e.dden, e.dst},
                            "R3", "drift fields", {offset_ns, drift_num, drift_den, drift_state},
                            {e.off, e.dnum, e.dden, e.dst});
                        last_f.off = e.off; last_f.dnum = e.dnum; last_f.dden = e.dden; last_f.dst = e.dst;
                    end
                    default: begin
                        chk(alt_valid, "R4", "alt_valid", {tod_valid, drift_valid, alt_valid}, 3'b001);
                        chk({alt_offset_ns, alt_sec} == {e.aoff, e.asec}, "R4", "alt fields",
                            {alt_offset_ns, alt_sec}, {e.aoff, e.asec});
                        last_f.aoff = e.aoff; last_f.asec = e.asec;
                    end
                endcase
                // R1 R5 R9: shared fields present in the same cycle as the pulse
                chk(act_common() == exp_common(e), "R5", "shared fields", act_common(), exp_common(e));
                last_f.rel = e.rel; last_f.frac = e.frac; last_f.pfns = e.pfns;
                last_f.pns = e.pns; last_f.rupd = e.rupd; last_f.slsb = e.slsb;
            end
        end
    end

    task automatic check_hold(input string req);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, req, "pending expected messages", exp_q.size(), 0);
        chk(act_common() == exp_common(last_f), req, "shared fields hold",
            act_common(), exp_common(last_f));
        chk(act_spec() == exp_spec(last_f), req, "typed fields hold", act_spec(), exp_spec(last_f));
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired R1 actual=running expected=finished");
        finish_run();
    end

    initial begin
        rst = 1'b1;
        td_sdi = 1'b1;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk({tod_valid, drift_valid, alt_valid} == 0, "R10", "valids after reset",
            {tod_valid, drift_valid, alt_valid}, 0);
        chk(act_common() == 0 && act_spec() == 0, "R10", "outputs after reset",
            {act_common(), act_spec()}, 0);
        for (int i = 0; i < 40; i++) drive_bit(1'b1);

        // R1 R2 R3 R4 R5: full rotation, twice, with different contents
        for (int s = 1; s <= 6; s++) send_good(s, 2'((s - 1) % 3));
        check_hold("R1");

        // R6: out-of-range indices are dropped
        send_frame(pack_msg(make_fld(20, 2'd0), 4'd3), 14);
        send_frame(pack_msg(make_fld(21, 2'd0), 4'd15), 14);
        check_hold("R6");

        // R7: high at a start-bit slot aborts the message
        send_frame(pack_msg(make_fld(22, 2'd0), 4'd0), 5);
        send_frame(pack_msg(make_fld(23, 2'd2), 4'd2), 13);
        check_hold("R7");
        send_good(7, 2'd1);
        check_hold("R7");

        // R8: message started without a full word time of idle is lost
        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        #1 rst = 1'b0;
        last_f = '0;
        for (int i = 0; i < 10; i++) drive_bit(1'b1);
        send_frame(pack_msg(make_fld(24, 2'd0), 4'd0), 14);
        check_hold("R8");
        send_good(8, 2'd0);
        check_hold("R8");

        // R10: reset in the middle of word 5 while the line keeps toggling
        fork
            send_frame(pack_msg(make_fld(25, 2'd2), 4'd2), 14);
            begin
                repeat (95) @(posedge clk);
                #1 rst = 1'b1;
                @(posedge clk);
                #1 rst = 1'b0;
                last_f = '0;
                @(negedge clk);
                chk(act_common() == 0 && act_spec() == 0, "R10", "outputs after mid reset",
                    {act_common(), act_spec()}, 0);
            end
        join
        check_hold("R10");
        send_good(9, 2'd2);
        send_good(10, 2'd0);
        check_hold("R10");

        finish_run();
    end

endmodule